// File: doc/BRIEF.md
# Synthesizer Configuration Latch

This block holds the configuration word of a frequency synthesizer: a 9-bit loop divider value, a 2-bit output divider select and a 3-bit test mode field. The word can be written in two ways.

The first way is a three-wire serial port with data, clock and load lines. Bits are shifted into a 14-bit chain. While the serial load line is high, the held word follows the chain.

The second way is a parallel pin bus with its own load line. While that line is low, the held divider fields follow the pins. The test field can only be reached from the serial side.

The held word is the block's only output, and it drives the dividers downstream. All inputs are treated as asynchronous. They are synchronized into the system clock domain, and both load lines are modelled as level-transparent latches that are re-evaluated on every system clock.

Top module: `synth_cfg_latch`

## Requirements
- R1: While rst_n is low, and at its release, cfgM, cfgN and cfgT are all zero, and the serial chain is cleared.
- R2: A rising edge on serClk shifts serData into bit 0 of the 14-bit chain, and every other bit moves up one place. There is no change in the chain without such an edge.
- R3: After 14 serial clocks, chain bits [13:11] hold T, bits [10:9] hold N and bits [8:0] hold M. The first bit shifted in ends as T[2], and the last bit ends as M[0]. M[8] is the most significant bit of the divider value.
- R4: While serLoad is high and parLoad is high, cfgM, cfgN and cfgT follow the chain. The value present when serLoad falls is held.
- R5: While parLoad is low, cfgM and cfgN follow parM and parN. The value present when parLoad rises is held.
- R6: When parLoad is low and serLoad is high together, cfgM and cfgN come from the parallel pins, and cfgT keeps its value.
- R7: cfgT changes only through the serial path. A parallel load leaves it untouched.
- R8: With serLoad low and parLoad high, shifting and pin changes leave cfgM, cfgN and cfgT unchanged.
- R9: A change on any input reaches the outputs after SYNC_STAGES+1 rising edges of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serData | input | 1 | Serial data, idle low |
| serClk | input | 1 | Serial shift clock, sampled on its rising edge, idle low |
| serLoad | input | 1 | Serial load line, transparent when high, idle low |
| parLoad | input | 1 | Parallel load line, transparent when low, idle high |
| parM | input | 9 | Parallel loop divider value, bit 8 is the MSB |
| parN | input | 2 | Parallel output divider select |
| cfgM | output | 9 | Held loop divider value |
| cfgN | output | 2 | Held output divider select |
| cfgT | output | 3 | Held test mode field |

## Verification
A chain bit that is dropped or misordered stays hidden until a serial load opens the latch. At that point it appears as a wrong field value SYNC_STAGES+1 cycles later. For that reason, the bench loads words with distinct bit patterns in every field.

A wrong priority or a leaking hold state shows up at once, within the same latency. It appears as outputs that move while no strobe is open, or as a test field that changes on a parallel load. The bench therefore changes the pins and the chain after every strobe closes and rechecks the outputs.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int CHAIN_W = M_W + N_W + T_W;

  typedef struct packed {
    logic shiftEn;
    logic serOpen;
    logic parOpen;
  } strobe_t;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stageQ[s] <= RST_VAL;
        else if (s == 0) stageQ[s] <= din;
        else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    serClkS,
  input  logic    serLoadS,
  input  logic    parLoadS,
  output strobe_t strb
);
  logic serClkPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serClkPrev <= 1'b0;
    else        serClkPrev <= serClkS;
  end

  always_comb begin
    strb.shiftEn = serClkS && !serClkPrev;
    strb.parOpen = !parLoadS;
    strb.serOpen = serLoadS && parLoadS;
  end
endmodule

// File: rtl/synth_cfg_datapath.sv
module synth_cfg_datapath
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  strobe_t        strb,
  input  logic           serDataS,
  input  logic [M_W-1:0] parMS,
  input  logic [N_W-1:0] parNS,
  output logic [M_W-1:0] cfgM,
  output logic [N_W-1:0] cfgN,
  output logic [T_W-1:0] cfgT
);
  localparam int M_LO = 0;
  localparam int N_LO = M_W;
  localparam int T_LO = M_W + N_W;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chain <= '0;
    else if (strb.shiftEn) chain <= {chain[CHAIN_W-2:0], serDataS};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgM <= '0;
      cfgN <= '0;
      cfgT <= '0;
    end else if (strb.parOpen) begin
      cfgM <= parMS;
      cfgN <= parNS;
    end else if (strb.serOpen) begin
      cfgM <= chain[M_LO +: M_W];
      cfgN <= chain[N_LO +: N_W];
      cfgT <= chain[T_LO +: T_W];
    end
  end

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shiftEn |=> chain[0] == $past(serDataS));

  assert_chain_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.shiftEn |=> $stable(chain));

  assert_ser_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.serOpen |=> cfgT == $past(chain[T_LO +: T_W]) && cfgM == $past(chain[M_LO +: M_W]));

  assert_par_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.parOpen |=> cfgM == $past(parMS) && cfgN == $past(parNS));

  assert_t_serial_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.serOpen |=> $stable(cfgT));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.serOpen || strb.parOpen) |=> $stable(cfgM) && $stable(cfgN));
endmodule

// File: rtl/synth_cfg_latch.sv
module synth_cfg_latch
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           serData,
  input  logic           serClk,
  input  logic           serLoad,
  input  logic           parLoad,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  output logic [M_W-1:0] cfgM,
  output logic [N_W-1:0] cfgN,
  output logic [T_W-1:0] cfgT
);
  localparam int BUS_W = 4 + M_W + N_W;
  localparam logic [BUS_W-1:0] BUS_RST = {4'b0001, {(M_W+N_W){1'b0}}};

  logic [BUS_W-1:0] rawBus;
  logic [BUS_W-1:0] syncBus;
  logic             serDataS, serClkS, serLoadS, parLoadS;
  logic [M_W-1:0]   parMS;
  logic [N_W-1:0]   parNS;
  strobe_t          strb;

  assign rawBus = {serData, serClk, serLoad, parLoad, parM, parN};
  assign {serDataS, serClkS, serLoadS, parLoadS, parMS, parNS} = syncBus;

  synth_cfg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rawBus), .dout(syncBus)
  );

  synth_cfg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .serClkS(serClkS), .serLoadS(serLoadS),
    .parLoadS(parLoadS), .strb(strb)
  );

  synth_cfg_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .serDataS(serDataS),
    .parMS(parMS), .parNS(parNS), .cfgM(cfgM), .cfgN(cfgN), .cfgT(cfgT)
  );
endmodule

// File: tb/synth_cfg_latch_bench.sv
module synth_cfg_latch_bench;
  localparam int SYNC_STAGES = 2;
  localparam int SETTLE = SYNC_STAGES + 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       serData = 1'b0, serClk = 1'b0, serLoad = 1'b0, parLoad = 1'b1;
  logic [8:0] parM = 9'h1FF;
  logic [1:0] parN = 2'b11;
  logic [8:0] cfgM;
  logic [1:0] cfgN;
  logic [2:0] cfgT;

  int total = 0;
  int bad = 0;
  logic [13:0] chainModel = '0;
  logic [13:0] heldModel = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  synth_cfg_latch #(.SYNC_STAGES(SYNC_STAGES)) u_synth_cfg_latch (
    .clk(clk), .rst_n(rst_n), .serData(serData), .serClk(serClk),
    .serLoad(serLoad), .parLoad(parLoad), .parM(parM), .parN(parN),
    .cfgM(cfgM), .cfgN(cfgN), .cfgT(cfgT)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [13:0] exp);
    logic [13:0] act;
    act = {cfgT, cfgN, cfgM};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual T=%0d N=%0d M=%h expected T=%0d N=%0d M=%h",
               req, act[13:11], act[10:9], act[8:0], exp[13:11], exp[10:9], exp[8:0]);
    end
  endtask

  task automatic shiftBit(logic b);
    serData = b; step(SETTLE);
    serClk = 1'b1; step(SETTLE);
    serClk = 1'b0; step(SETTLE);
    chainModel = {chainModel[12:0], b};
  endtask

  task automatic shiftWord(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    logic [13:0] w;
    w = {t, n, m};
    for (int i = 13; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic testReset;
    step(2);
    check("R1 during reset", 14'h0);
    rst_n = 1'b1;
    step(1);
    check("R1 after release", 14'h0);
  endtask

  task automatic testParallel;
    parM = 9'h1A5; parN = 2'b10; parLoad = 1'b0; step(SETTLE);
    heldModel = {heldModel[13:11], 2'b10, 9'h1A5};
    check("R5 transparent", heldModel);
    parM = 9'h03C; parN = 2'b01; step(SETTLE);
    heldModel = {heldModel[13:11], 2'b01, 9'h03C};
    check("R5 follows pins", heldModel);
    parLoad = 1'b1; step(SETTLE);
    parM = 9'h111; parN = 2'b00; step(SETTLE);
    check("R5 held after rise", heldModel);
  endtask

  task automatic testSerial;
    shiftWord(3'b101, 2'b01, 9'h0C3);
    check("R8 shift without load", heldModel);
    check("R2 chain model", {3'b101, 2'b01, 9'h0C3} == chainModel ? heldModel : 14'h3FFF);
    serLoad = 1'b1; step(SETTLE);
    heldModel = chainModel;
    check("R3 field order", {3'b101, 2'b01, 9'h0C3});
    serLoad = 1'b0; step(SETTLE);
    shiftWord(3'b010, 2'b10, 9'h155);
    check("R4 held after fall", heldModel);
  endtask

  task automatic testSerialTransparent;
    serLoad = 1'b1; step(SETTLE);
    heldModel = chainModel;
    check("R4 open shows chain", heldModel);
    shiftBit(1'b1); shiftBit(1'b0); shiftBit(1'b1);
    heldModel = chainModel;
    check("R4 follows shifting", heldModel);
    serLoad = 1'b0; step(SETTLE);
    shiftBit(1'b0);
    check("R4 hold after close", heldModel);
  endtask

  task automatic testPriority;
    logic [2:0] tBefore;
    tBefore = cfgT;
    shiftWord(3'b110, 2'b11, 9'h0F0);
    parM = 9'h055; parN = 2'b11;
    parLoad = 1'b0; serLoad = 1'b1; step(SETTLE);
    heldModel = {tBefore, 2'b11, 9'h055};
    check("R6 parallel wins", heldModel);
    check("R7 T kept on parallel load", {tBefore, cfgN, cfgM});
    parLoad = 1'b1; step(SETTLE);
    heldModel = chainModel;
    check("R6 serial after release", {3'b110, 2'b11, 9'h0F0});
    serLoad = 1'b0; step(SETTLE);
  endtask

  task automatic testLatency;
    parM = 9'h0AA; parN = 2'b01;
    @(negedge clk); parLoad = 1'b0;
    repeat (SYNC_STAGES) @(posedge clk);
    #1 check("R9 not yet", heldModel);
    @(posedge clk); #1;
    heldModel = {heldModel[13:11], 2'b01, 9'h0AA};
    check("R9 after SYNC_STAGES+1", heldModel);
    @(negedge clk); parLoad = 1'b1; step(SETTLE);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testParallel();
    testSerial();
    testSerialTransparent();
    testPriority();
    testLatency();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule